// File: doc/BRIEF.md
# Fault Confinement Counter Unit

This block keeps the two error tallies of a CAN node, one for faults it causes while sending and one for faults it sees while listening, and turns them into the node's fault state: Active, Passive or Off. The error and success events arrive as single-cycle pulses from the protocol engine. The tallies rise by unequal steps on errors and fall by one on each clean frame. A transmitter that keeps failing therefore silences itself quickly, and a node that only witnesses faults stays on the bus.

A second, independent part watches the sampled bus level and raises an idle flag once enough consecutive recessive bits have been seen. Leaving the Off state is left to the surrounding logic. The only part of that procedure handled here is a recovery pulse, which wipes both tallies.

Top module: `can_fault_confine`

## Requirements
- R1: A `tx_err` pulse raises `tec` by 8. Outside the Off state, `tec` never exceeds 263, so the 9-bit counter cannot wrap.
- R2: An `rx_err` pulse raises `rec` by 1. `rec` saturates at 511 and stays there on further errors.
- R3: A `tx_ok` pulse lowers `tec` by 1, and an `rx_ok` pulse lowers `rec` by 1. Neither counter goes below 0.
- R4: When an error pulse and a success pulse for the same counter arrive in one cycle, the error is applied first. `tec` gains 7 net, and `rec` is left unchanged unless it is saturated.
- R5: `state` is 2'b00 (Active) while both counters are at 127 or below. It is 2'b01 (Passive) when either counter is 128 or more and `tec` is at most 255. A value of 127 is still Active.
- R6: `state` is 2'b10 (Off) exactly when `tec` exceeds 255. A `tec` of 255 is not Off, and no `rec` value alone causes Off. While Off, error and success pulses leave both counters unchanged.
- R7: A `recover` pulse while Off clears both counters, which returns `state` to Active. A `recover` pulse in any other state has no effect.
- R8: `bus_idle` rises after the 11th consecutive sample with `bit_valid`=1 and `bus_bit`=1. A sample with `bus_bit`=0 clears it at once. Cycles with `bit_valid`=0 change nothing.
- R9: After reset both counters are 0, `state` is Active and `bus_idle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err | input | 1 | Error pulse while transmitting |
| rx_err | input | 1 | Error pulse while receiving |
| tx_ok | input | 1 | Successful transmission pulse |
| rx_ok | input | 1 | Successful reception pulse |
| recover | input | 1 | Recovery pulse, acts only in the Off state |
| bit_valid | input | 1 | Strobe marking a new bus sample |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| state | output | 2 | 00 Active, 01 Passive, 10 Off |
| bus_idle | output | 1 | Idle bus detected |

## Verification
Runs of transmit errors walk `tec` through 120, 128, 127, 255 and 263. This separates a strict threshold from an inclusive one at both the Passive and the Off boundary. Receive-only runs drive `rec` past 127 and up to saturation, which shows that `rec` alone can never cause Off. Paired error and success pulses fix the order in which the two are applied. Recessive runs of 10 and 11 samples, broken by a dominant sample or padded with cycles where `bit_valid` is low, tell a correct idle count from an off-by-one count or one that runs on every clock.

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
  parameter int CNT_W         = 9,
  parameter int TX_ERR_STEP   = 8,
  parameter int RX_ERR_STEP   = 1,
  parameter int PASSIVE_LIMIT = 127,
  parameter int BUSOFF_LIMIT  = 255,
  parameter int IDLE_RUN      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err,
  input  logic             rx_err,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             recover,
  input  logic             bit_valid,
  input  logic             bus_bit,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [1:0]       state,
  output logic             bus_idle
);
  localparam int IDLE_W = $clog2(IDLE_RUN + 1);
  localparam logic [CNT_W:0]   SUM_MAX  = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] PASS_TH  = CNT_W'(PASSIVE_LIMIT);
  localparam logic [CNT_W-1:0] OFF_TH   = CNT_W'(BUSOFF_LIMIT);
  localparam logic [IDLE_W-1:0] IDLE_TOP = IDLE_W'(IDLE_RUN);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic err, input logic ok,
                                            input int inc);
    logic [CNT_W:0] s;
    s = {1'b0, v} + (err ? (CNT_W+1)'(inc) : '0);
    if (s > SUM_MAX) s = SUM_MAX;
    if (ok && s != '0) s = s - 1'b1;
    return s[CNT_W-1:0];
  endfunction

  logic              off;
  logic [IDLE_W-1:0] idle_cnt;

  assign off      = tec > OFF_TH;
  assign state    = off ? 2'b10 : ((tec > PASS_TH || rec > PASS_TH) ? 2'b01 : 2'b00);
  assign bus_idle = idle_cnt == IDLE_TOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec <= '0;
      rec <= '0;
    end else if (off) begin
      if (recover) begin
        tec <= '0;
        rec <= '0;
      end
    end else begin
      tec <= step(tec, tx_err, tx_ok, TX_ERR_STEP);
      rec <= step(rec, rx_err, rx_ok, RX_ERR_STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idle_cnt <= '0;
    else if (bit_valid) begin
      if (!bus_bit)
        idle_cnt <= '0;
      else if (!bus_idle)
        idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/can_fault_confine_chk.sv
module can_fault_confine_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err,
  input logic             rx_err,
  input logic             tx_ok,
  input logic             rx_ok,
  input logic             recover,
  input logic             bit_valid,
  input logic             bus_bit,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic [1:0]       state,
  input logic             bus_idle
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic is_off;
  assign is_off = state == 2'b10;

  AST_TX_ERR_ADDS_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_ok && !is_off) |=> tec == $past(tec) + CNT_W'(8)); // R1
  AST_RX_ERR_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !rx_ok && !is_off && rec != CMAX) |=> rec == $past(rec) + CNT_W'(1)); // R2
  AST_REC_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !is_off && rec == CMAX) |=> rec == CMAX); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && !tx_err && !is_off && tec == '0) |=> tec == '0); // R3
  AST_ERR_BEFORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && tx_ok && !is_off) |=> tec == $past(tec) + CNT_W'(7)); // R4
  AST_OFF_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && !recover) |=> is_off && $stable(tec) && $stable(rec)); // R6
  AST_RECOVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_off && recover) |=> tec == '0 && rec == '0 && state == 2'b00); // R7
  AST_DOMINANT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bus_bit) |=> !bus_idle); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'b11); // R5
endmodule

bind can_fault_confine can_fault_confine_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/can_fault_confine_tb.sv
module can_fault_confine_tb;
  logic clk = 0, rst_n = 0;
  logic tx_err = 0, rx_err = 0, tx_ok = 0, rx_ok = 0, recover = 0;
  logic bit_valid = 0, bus_bit = 0;
  logic [8:0] tec, rec;
  logic [1:0] state;
  logic bus_idle;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  can_fault_confine u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic pulse(logic te, logic re, logic to, logic ro, logic rc);
    @(negedge clk);
    {tx_err, rx_err, tx_ok, rx_ok, recover} = {te, re, to, ro, rc};
    @(negedge clk);
    {tx_err, rx_err, tx_ok, rx_ok, recover} = '0;
  endtask

  task automatic sample(logic v, logic b);
    @(negedge clk); bit_valid = v; bus_bit = b;
    @(negedge clk); bit_valid = 0; bus_bit = 0;
  endtask

  task automatic t_reset();
    check("R9 tec", tec, 0);
    check("R9 rec", rec, 0);
    check("R9 state", state, 0);
    check("R9 idle", bus_idle, 0);
  endtask

  task automatic t_tx_path();
    do_reset();
    for (int i = 0; i < 15; i++) pulse(1, 0, 0, 0, 0);
    check("R1 tec", tec, 120);
    check("R5 active at 120", state, 0);
    pulse(1, 0, 0, 0, 0);
    check("R1 tec", tec, 128);
    check("R5 passive at 128", state, 1);
    pulse(0, 0, 1, 0, 0);
    check("R3 tec", tec, 127);
    check("R5 active at 127", state, 0);
    pulse(0, 0, 0, 0, 1);
    check("R7 recover ignored", tec, 127);
    for (int i = 0; i < 16; i++) pulse(1, 0, 0, 0, 0);
    check("R6 tec", tec, 255);
    check("R6 not off at 255", state, 1);
    pulse(1, 0, 0, 0, 0);
    check("R1 tec", tec, 263);
    check("R6 off", state, 2);
    pulse(1, 1, 1, 1, 0);
    check("R6 frozen tec", tec, 263);
    check("R6 frozen rec", rec, 0);
    check("R6 still off", state, 2);
    pulse(0, 0, 0, 0, 1);
    check("R7 tec cleared", tec, 0);
    check("R7 active", state, 0);
  endtask

  task automatic t_rx_path();
    do_reset();
    for (int i = 0; i < 128; i++) pulse(0, 1, 0, 0, 0);
    check("R2 rec", rec, 128);
    check("R5 passive by rec", state, 1);
    pulse(0, 0, 0, 1, 0);
    check("R3 rec", rec, 127);
    check("R5 active", state, 0);
    for (int i = 0; i < 400; i++) pulse(0, 1, 0, 0, 0);
    check("R2 saturated", rec, 511);
    check("R6 rec never off", state, 1);
    pulse(0, 0, 0, 0, 1);
    check("R7 recover ignored rec", rec, 511);
  endtask

  task automatic t_floor_and_order();
    do_reset();
    pulse(0, 0, 1, 1, 0);
    check("R3 tec floor", tec, 0);
    check("R3 rec floor", rec, 0);
    pulse(1, 0, 1, 0, 0);
    check("R4 tec", tec, 7);
    pulse(0, 1, 0, 1, 0);
    check("R4 rec", rec, 0);
    for (int i = 0; i < 3; i++) pulse(0, 1, 0, 0, 0);
    pulse(0, 1, 0, 1, 0);
    check("R4 rec", rec, 3);
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 10; i++) sample(1, 1);
    check("R8 not idle at 10", bus_idle, 0);
    sample(1, 1);
    check("R8 idle at 11", bus_idle, 1);
    sample(0, 0);
    check("R8 invalid ignored", bus_idle, 1);
    sample(1, 0);
    check("R8 dominant clears", bus_idle, 0);
    for (int i = 0; i < 5; i++) sample(1, 1);
    sample(0, 0);
    for (int i = 0; i < 5; i++) sample(1, 1);
    check("R8 not idle at 10 with gap", bus_idle, 0);
    sample(1, 1);
    check("R8 idle at 11 with gap", bus_idle, 1);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_tx_path();
    t_rx_path();
    t_floor_and_order();
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule